// File: doc/BRIEF.md
# Home-Bank Presence Tracker

This block belongs to one home bank of a distributed shared cache. For every cache set it keeps a bit vector with one bit per candidate bank. A bit is high while that bank holds at least one block whose home is this bank. A requester that misses close by asks the home for the vector. It then probes only the banks that are marked, and does not broadcast to all of them.

Three kinds of event keep the vectors exact. An insert adds a block to a bank. An evict removes a block from a bank. A migrate moves a block from one bank to another and is applied as a single combined update. Behind each vector bit there is an occupancy counter for that set and bank. The counter runs from zero up to the bank's associativity, and a bit drops only when its counter returns to zero. Events arrive on a valid/ready pair. Lookups return the vector of a set one cycle after they are issued. A lookup issued together with an update to the same set sees the updated vector.

Top module: `hk_presence_tracker`

## Requirements
- R1: The reset is asserted asynchronously and released synchronously. After release, every set's vector reads all zero and `ev_ready` rises within three clock cycles.
- R2: An insert event (`ev_kind` = 2'b00) into bank `ev_dst` of set `ev_set` adds one to that bank's count and sets bit `ev_dst` of the set's vector.
- R3: An evict event (`ev_kind` = 2'b01) from bank `ev_src` subtracts one from that bank's count. The bit stays set while the count is above zero and clears on the evict that brings the count to zero.
- R4: A migrate event (`ev_kind` = 2'b10) moves one block from `ev_src` to `ev_dst` in one cycle. The source count goes down and the destination count goes up, and no lookup ever sees a half-applied move.
- R5: A migrate whose source and destination are the same bank leaves the counts and the vector unchanged.
- R6: A lookup with `q_valid` high is answered with `r_valid` high and the vector on `r_vec` on the next cycle. In any cycle that follows no lookup, `r_valid` is low.
- R7: A lookup issued in the same cycle as an accepted event to the same set returns the vector after that event (write-first).
- R8: The counts never go above WAYS (8 by default) or below zero. An insert into a full bank, an evict from an empty bank, and a migrate from an empty source or into a full destination are each ignored as a whole.
- R9: An event with the reserved kind 2'b11 changes nothing.
- R10: An event to one set leaves the vectors of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Update event present |
| ev_ready | output | 1 | Tracker accepts events |
| ev_kind | input | 2 | 00 insert, 01 evict, 10 migrate, 11 reserved |
| ev_set | input | SW (4) | Set index of the event |
| ev_src | input | BW (4) | Bank losing a block (evict, migrate) |
| ev_dst | input | BW (4) | Bank gaining a block (insert, migrate) |
| q_valid | input | 1 | Lookup request |
| q_set | input | SW (4) | Set index of the lookup |
| r_valid | output | 1 | Lookup response valid |
| r_vec | output | NUM_BANKS (16) | Presence vector of the looked-up set |

## Verification
A wrong counter stays hidden until that bank's last block leaves. Then the bit clears one evict too early or stays set after the bank is empty, and the first lookup after that evict shows it. A bank is filled past its associativity and drained again so that a counter that wraps or saturates in the wrong place shows up as a bit error at a known evict. A bypass fault or a misrouted set shows on the very lookup that goes with the event, because every step compares the vector one cycle after it is issued.

// File: rtl/hk_pkg.sv
package hk_pkg;
  typedef enum logic [1:0] {
    EV_INSERT  = 2'b00,
    EV_EVICT   = 2'b01,
    EV_MIGRATE = 2'b10,
    EV_RSVD    = 2'b11
  } ev_kind_e;
endpackage

// File: rtl/hk_rst_sync.sv
module hk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/hk_upd_decode.sv
module hk_upd_decode #(
  parameter int NUM_BANKS = 16,
  parameter int WAYS      = 8,
  parameter int CW        = $clog2(WAYS + 1),
  parameter int BW        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                          ev_fire,
  input  logic [1:0]                    ev_kind,
  input  logic [BW-1:0]                 ev_src,
  input  logic [BW-1:0]                 ev_dst,
  input  logic [NUM_BANKS-1:0][CW-1:0]  cur_cnt,
  output logic [NUM_BANKS-1:0]          inc_mask,
  output logic [NUM_BANKS-1:0]          dec_mask
);
  import hk_pkg::*;

  ev_kind_e kind;
  logic     src_has;
  logic     dst_room;
  logic     same_bank;

  assign kind      = ev_kind_e'(ev_kind);
  assign src_has   = (cur_cnt[ev_src] != '0);
  assign dst_room  = (cur_cnt[ev_dst] < CW'(WAYS));
  assign same_bank = (ev_src == ev_dst);

  always_comb begin
    inc_mask = '0;
    dec_mask = '0;
    if (ev_fire) begin
      unique case (kind)
        EV_INSERT: begin
          if (dst_room) inc_mask[ev_dst] = 1'b1;
        end
        EV_EVICT: begin
          if (src_has) dec_mask[ev_src] = 1'b1;
        end
        EV_MIGRATE: begin
          if (!same_bank && src_has && dst_room) begin
            inc_mask[ev_dst] = 1'b1;
            dec_mask[ev_src] = 1'b1;
          end
        end
        default: begin
          inc_mask = '0;
          dec_mask = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/hk_set_slice.sv
module hk_set_slice #(
  parameter int NUM_BANKS = 16,
  parameter int WAYS      = 8,
  parameter int CW        = $clog2(WAYS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel,
  input  logic [NUM_BANKS-1:0]          inc_mask,
  input  logic [NUM_BANKS-1:0]          dec_mask,
  output logic [NUM_BANKS-1:0][CW-1:0]  cnt_o,
  output logic [NUM_BANKS-1:0]          vec_o,
  output logic [NUM_BANKS-1:0]          vec_nxt_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CW-1:0] cnt_q, cnt_d;
    logic          vec_q, vec_d;
    logic          en;

    assign en = sel && (inc_mask[b] ^ dec_mask[b]);

    always_comb begin
      cnt_d = cnt_q;
      vec_d = vec_q;
      if (sel && inc_mask[b] && !dec_mask[b]) begin
        cnt_d = cnt_q + CW'(1);
        vec_d = 1'b1;
      end else if (sel && dec_mask[b] && !inc_mask[b]) begin
        cnt_d = cnt_q - CW'(1);
        vec_d = (cnt_q != CW'(1));
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        vec_q <= 1'b0;
      end else if (en) begin
        cnt_q <= cnt_d;
        vec_q <= vec_d;
      end
    end

    assign cnt_o[b]     = cnt_q;
    assign vec_o[b]     = vec_q;
    assign vec_nxt_o[b] = vec_d;
  end
endmodule

// File: rtl/hk_presence_tracker.sv
module hk_presence_tracker #(
  parameter int NUM_SETS  = 16,
  parameter int NUM_BANKS = 16,
  parameter int WAYS      = 8,
  localparam int CW       = $clog2(WAYS + 1),
  localparam int SW       = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_valid,
  output logic                 ev_ready,
  input  logic [1:0]           ev_kind,
  input  logic [SW-1:0]        ev_set,
  input  logic [BW-1:0]        ev_src,
  input  logic [BW-1:0]        ev_dst,
  input  logic                 q_valid,
  input  logic [SW-1:0]        q_set,
  output logic                 r_valid,
  output logic [NUM_BANKS-1:0] r_vec
);
  logic rst_sync_n;
  logic ev_fire;
  logic rdy_q;

  logic [NUM_BANKS-1:0][CW-1:0] cnt_all     [NUM_SETS];
  logic [NUM_BANKS-1:0]         vec_all     [NUM_SETS];
  logic [NUM_BANKS-1:0]         vec_nxt_all [NUM_SETS];
  logic [NUM_BANKS-1:0][CW-1:0] cur_cnt;
  logic [NUM_BANKS-1:0]         inc_mask;
  logic [NUM_BANKS-1:0]         dec_mask;

  logic [NUM_SETS*NUM_BANKS*CW-1:0] cnt_flat;
  logic [NUM_SETS*NUM_BANKS-1:0]    vec_flat;

  logic                 r_valid_q, r_valid_d;
  logic [NUM_BANKS-1:0] r_vec_q, r_vec_d;
  logic                 r_vec_en;

  hk_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdy_q <= 1'b0;
    else             rdy_q <= 1'b1;
  end

  assign ev_ready = rdy_q;
  assign ev_fire  = ev_valid && rdy_q && (int'(ev_set) < NUM_SETS);

  always_comb begin
    cur_cnt = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (ev_set == SW'(s)) cur_cnt = cnt_all[s];
    end
  end

  hk_upd_decode #(
    .NUM_BANKS (NUM_BANKS),
    .WAYS      (WAYS),
    .CW        (CW),
    .BW        (BW)
  ) u_decode (
    .ev_fire  (ev_fire),
    .ev_kind  (ev_kind),
    .ev_src   (ev_src),
    .ev_dst   (ev_dst),
    .cur_cnt  (cur_cnt),
    .inc_mask (inc_mask),
    .dec_mask (dec_mask)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic sel;
    assign sel = ev_fire && (ev_set == SW'(s));

    hk_set_slice #(
      .NUM_BANKS (NUM_BANKS),
      .WAYS      (WAYS),
      .CW        (CW)
    ) u_slice (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .sel       (sel),
      .inc_mask  (inc_mask),
      .dec_mask  (dec_mask),
      .cnt_o     (cnt_all[s]),
      .vec_o     (vec_all[s]),
      .vec_nxt_o (vec_nxt_all[s])
    );

    assign cnt_flat[s*NUM_BANKS*CW +: NUM_BANKS*CW] = cnt_all[s];
    assign vec_flat[s*NUM_BANKS +: NUM_BANKS]       = vec_all[s];
  end

  always_comb begin
    r_valid_d = q_valid;
    r_vec_en  = q_valid;
    r_vec_d   = r_vec_q;
    if (q_valid) begin
      r_vec_d = '0;
      for (int s = 0; s < NUM_SETS; s++) begin
        if (q_set == SW'(s)) r_vec_d = vec_nxt_all[s];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      r_valid_q <= 1'b0;
    end else begin
      r_valid_q <= r_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      r_vec_q <= '0;
    end else if (r_vec_en) begin
      r_vec_q <= r_vec_d;
    end
  end

  assign r_valid = r_valid_q;
  assign r_vec   = r_vec_q;
endmodule

// File: rtl/hk_presence_chk.sv
module hk_presence_chk #(
  parameter int NUM_SETS  = 16,
  parameter int NUM_BANKS = 16,
  parameter int WAYS      = 8,
  parameter int CW        = 4,
  parameter int BW        = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ev_fire,
  input  logic [1:0]                    ev_kind,
  input  logic [BW-1:0]                 ev_src,
  input  logic [BW-1:0]                 ev_dst,
  input  logic                          q_valid,
  input  logic                          r_valid,
  input  logic [NUM_SETS*NUM_BANKS*CW-1:0] cnt_flat,
  input  logic [NUM_SETS*NUM_BANKS-1:0]    vec_flat
);
  assert_resp_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |=> r_valid);

  assert_no_stray_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |=> !r_valid);

  assert_same_bank_noop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_kind == 2'b10 && ev_src == ev_dst) |=> $stable(cnt_flat));

  assert_rsvd_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_kind == 2'b11) |=> $stable(cnt_flat));

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_fire |=> $stable(cnt_flat));

  for (genvar i = 0; i < NUM_SETS*NUM_BANKS; i++) begin : g_cell
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[i*CW +: CW] <= CW'(WAYS));

    assert_bit_tracks_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_flat[i] == (cnt_flat[i*CW +: CW] != '0));
  end
endmodule

bind hk_presence_tracker hk_presence_chk #(
  .NUM_SETS  (NUM_SETS),
  .NUM_BANKS (NUM_BANKS),
  .WAYS      (WAYS),
  .CW        (CW),
  .BW        (BW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ev_fire  (ev_fire),
  .ev_kind  (ev_kind),
  .ev_src   (ev_src),
  .ev_dst   (ev_dst),
  .q_valid  (q_valid),
  .r_valid  (r_valid),
  .cnt_flat (cnt_flat),
  .vec_flat (vec_flat)
);

// File: tb/hk_presence_tracker_tb.sv
`timescale 1ns/1ps
module hk_presence_tracker_tb;
  localparam int NS = 16;
  localparam int NB = 16;
  localparam int WY = 8;

  logic        clk;
  logic        rst_n;
  logic        ev_valid;
  logic        ev_ready;
  logic [1:0]  ev_kind;
  logic [3:0]  ev_set, ev_src, ev_dst;
  logic        q_valid;
  logic [3:0]  q_set;
  logic        r_valid;
  logic [15:0] r_vec;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int mcnt [NS][NB];

  logic [15:0] exp_q [$];
  int          due_q [$];
  string       tag_q [$];

  hk_presence_tracker #(.NUM_SETS(NS), .NUM_BANKS(NB), .WAYS(WY)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_set(ev_set), .ev_src(ev_src), .ev_dst(ev_dst),
    .q_valid(q_valid), .q_set(q_set), .r_valid(r_valid), .r_vec(r_vec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] model_vec(int s);
    logic [15:0] v;
    for (int b = 0; b < NB; b++) v[b] = (mcnt[s][b] != 0);
    return v;
  endfunction

  task automatic model_apply(int k, int s, int src, int dst);
    case (k)
      0: if (mcnt[s][dst] < WY) mcnt[s][dst]++;
      1: if (mcnt[s][src] > 0) mcnt[s][src]--;
      2: if (src != dst && mcnt[s][src] > 0 && mcnt[s][dst] < WY) begin
           mcnt[s][src]--;
           mcnt[s][dst]++;
         end
      default: ;
    endcase
  endtask

  // Driver: one cycle, optional event and optional lookup; pushes expectation.
  task automatic step(bit ev, int k, int s, int src, int dst,
                      bit qv, int qs, string tag);
    ev_valid = ev;
    ev_kind  = 2'(k);
    ev_set   = 4'(s);
    ev_src   = 4'(src);
    ev_dst   = 4'(dst);
    q_valid  = qv;
    q_set    = 4'(qs);
    if (ev) model_apply(k, s, src, dst);
    if (qv) begin
      exp_q.push_back(model_vec(qs));
      due_q.push_back(cyc + 1);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    ev_valid = 1'b0;
    q_valid  = 1'b0;
  endtask

  task automatic ev_only(int k, int s, int src, int dst);
    step(1'b1, k, s, src, dst, 1'b0, 0, "");
  endtask

  task automatic look(int s, string tag);
    step(1'b0, 0, 0, 0, 0, 1'b1, s, tag);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0 && due_q[0] == cyc) begin
        n_cmp++;
        if (!r_valid) begin
          n_bad++;
          $display("FAIL %s: r_valid actual 0 expected 1", tag_q[0]);
        end else if (r_vec !== exp_q[0]) begin
          n_bad++;
          $display("FAIL %s: r_vec actual %h expected %h", tag_q[0], r_vec, exp_q[0]);
        end
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end else if (r_valid) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R6: r_valid actual 1 expected 0 (no lookup issued)");
      end
    end
  end

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: run actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) for (int b = 0; b < NB; b++) mcnt[s][b] = 0;
    rst_n = 1'b0; ev_valid = 1'b0; q_valid = 1'b0;
    ev_kind = 2'b00; ev_set = '0; ev_src = '0; ev_dst = '0; q_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: ready and empty vectors after reset
    n_cmp++;
    if (ev_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: ev_ready actual %b expected 1", ev_ready);
    end
    for (int s = 0; s < NS; s++) look(s, "R1 reset vector");

    // R2 + R7: insert with bypass lookup in same cycle
    step(1'b1, 0, 3, 0, 5, 1'b1, 3, "R2/R7 insert bypass");
    look(3, "R2 insert visible");

    // R3: second block in bank 5, first evict keeps bit, second clears
    ev_only(0, 3, 0, 5);
    step(1'b1, 1, 3, 5, 0, 1'b1, 3, "R3 evict keeps bit");
    step(1'b1, 1, 3, 5, 0, 1'b1, 3, "R3 evict clears bit");

    // R4: migrate 5 -> 9, combined update seen by bypass lookup
    ev_only(0, 3, 0, 5);
    step(1'b1, 2, 3, 5, 9, 1'b1, 3, "R4 migrate bypass");
    look(3, "R4 migrate after");

    // R5: same-bank migrate, then drain one to prove count unchanged
    step(1'b1, 2, 3, 9, 9, 1'b1, 3, "R5 same-bank migrate");
    step(1'b1, 1, 3, 9, 0, 1'b1, 3, "R5 count intact");

    // R8: fill bank 2 of set 7 past WAYS, then drain
    for (int i = 0; i < WY + 2; i++) ev_only(0, 7, 0, 2);
    for (int i = 0; i < WY - 1; i++) ev_only(1, 7, 2, 0);
    look(7, "R8 saturate keeps bit");
    step(1'b1, 1, 7, 2, 0, 1'b1, 7, "R8 saturate clears");

    // R8: evict from empty ignored (no wrap)
    ev_only(1, 7, 4, 0);
    ev_only(0, 7, 0, 4);
    step(1'b1, 1, 7, 4, 0, 1'b1, 7, "R8 no underflow");

    // R8: migrate into full destination ignored; from empty source ignored
    for (int i = 0; i < WY; i++) ev_only(0, 8, 0, 1);
    ev_only(0, 8, 0, 6);
    step(1'b1, 2, 8, 6, 1, 1'b1, 8, "R8 migrate to full");
    step(1'b1, 2, 8, 11, 6, 1'b1, 8, "R8 migrate from empty");
    for (int i = 0; i < WY; i++) ev_only(1, 8, 1, 0);
    look(8, "R8 full drained");

    // R9: reserved kind
    step(1'b1, 3, 8, 6, 12, 1'b1, 8, "R9 reserved kind");
    ev_only(1, 8, 6, 0);
    look(8, "R9 count intact");

    // R10: set isolation and bypass to a different set
    step(1'b1, 0, 0, 0, 0, 1'b1, 1, "R10 other set untouched");
    look(0, "R10 own set");
    step(1'b1, 0, 15, 0, 15, 1'b1, 0, "R10 cross-set bypass");
    look(15, "R10 top set");

    // R6: gap cycles with no lookup, then back-to-back lookups
    repeat (3) @(negedge clk);
    look(15, "R6 back-to-back a");
    look(3, "R6 back-to-back b");
    repeat (2) @(negedge clk);

    if (exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R6: pending responses actual %0d expected 0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule